// File: doc/BRIEF.md
# DTMF Digit Steering Validator

This block is the digital replacement for an analogue steering time constant behind a DTMF frequency detector. An upstream detector raises `pair_det` while it sees a valid tone pair and drives the 4-bit code of that pair on `det_code`. The validator times how long the pair stays present and how long it stays absent. It counts pulses of a timebase input `tick`, which is nominally 1 ms. Short bursts are rejected and short gaps inside a tone are ignored. A tone that qualifies has its code stored in a receive register, and the event is announced for a status or interrupt block.

Both inputs pass through a two-flop synchronizer. The synchronized copies then drive a five-state machine.

- `ST_IDLE`: no tone.
- `ST_ON_QUAL`: the on-guard timer is running.
- `ST_SETTLE`: the code is latched and the settle delay is in progress.
- `ST_HELD`: the tone is accepted.
- `ST_OFF_QUAL`: the off-guard timer is running.

The transitions are:

| From | To | Condition |
|---|---|---|
| `ST_IDLE` | `ST_ON_QUAL` | detect rise |
| `ST_ON_QUAL` | `ST_IDLE` | burst reject |
| `ST_ON_QUAL` | `ST_SETTLE` | accept |
| `ST_SETTLE` | `ST_HELD` | settle done |
| `ST_HELD` | `ST_OFF_QUAL` | detect fall |
| `ST_OFF_QUAL` | `ST_HELD` | dropout ride-through |
| `ST_OFF_QUAL` | `ST_IDLE` | release |

The guard limits are 16-bit tick counts. Forty ticks for each guard is the usual setting.

Top module: `dtmf_steer_top`

## Requirements
- R1: After reset the outputs are `rx_code` = 0, `steer_idle` = 1 and `code_strobe` = 0.
- R2: A tone is accepted once `pair_det` has stayed high continuously for `on_guard` ticks. On acceptance the synchronized `det_code` is stored in `rx_code`, and `code_strobe` is high for exactly one clock in the same cycle.
- R3: A burst of `pair_det` that is shorter than `on_guard` ticks produces no `code_strobe` and leaves `rx_code` unchanged.
- R4: While an accepted tone keeps `pair_det` high, the block stays accepted. `steer_idle` remains 0 and no further `code_strobe` occurs.
- R5: A low gap in `pair_det` shorter than `off_guard` ticks is a tolerated dropout. `steer_idle` stays 0, `rx_code` is unchanged and no `code_strobe` occurs.
- R6: The end of a tone is recognized after `pair_det` has stayed low for `off_guard` ticks. `steer_idle` then returns to 1, and `rx_code` keeps the last code until the next accepted tone.
- R7: `steer_idle` is active low for the duration of a valid signal. It falls exactly 2 clocks after the `code_strobe` cycle, and it is still 1 during the strobe cycle.
- R8: `on_guard` and `off_guard` act independently. Either one may be larger than the other.
- R9: A later tone that qualifies registers a new code, and the strobes follow tone order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse, one clock wide, nominally every 1 ms |
| pair_det | input | 1 | Raw early-detect flag from the frequency detector |
| det_code | input | 4 | Code of the detected tone pair |
| on_guard | input | 16 | Presence guard in ticks |
| off_guard | input | 16 | Absence guard in ticks |
| rx_code | output | 4 | Last accepted code |
| steer_idle | output | 1 | Delayed steering status, low while a valid tone is held |
| code_strobe | output | 1 | One-clock pulse on each registration |

## Verification
Suppose the state machine leaves `ST_OFF_QUAL` too early or keeps a stale timer count. That error shows at the ports as a second `code_strobe` for one tone, or as `steer_idle` rising during a dropout, within one guard period of the gap. Suppose instead that the settle counter or the latch enable is wrong. The stored code then disagrees with the scoreboard in the strobe cycle, or `steer_idle` falls at some distance from the strobe other than exactly 2 clocks. A missed acceptance leaves the scoreboard queue non-empty once the tone has ended.

// File: rtl/steer_pkg.sv
package steer_pkg;
    localparam int GUARD_W    = 16;
    localparam int CODE_W     = 4;
    localparam int SETTLE_CYC = 2;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ON_QUAL  = 3'd1,
        ST_SETTLE   = 3'd2,
        ST_HELD     = 3'd3,
        ST_OFF_QUAL = 3'd4
    } steer_state_t;
endpackage

// File: rtl/steer_sync.sv
module steer_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/steer_guard_timer.sv
module steer_guard_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (tick && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end

    assign done = (cnt >= limit);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt == CNT_MAX) |=> (!run || cnt == CNT_MAX)); // R6
endmodule

// File: rtl/steer_fsm.sv
module steer_fsm
    import steer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              det_s,
    input  logic [CODE_W-1:0] code_s,
    input  logic              guard_done,
    output logic              timer_run,
    output logic              sel_on,
    output logic [CODE_W-1:0] rx_code,
    output logic              steer_idle,
    output logic              code_strobe
);
    localparam int SW = $clog2(SETTLE_CYC + 1);
    localparam logic [SW-1:0] SETTLE_LAST = SW'(SETTLE_CYC - 1);

    steer_state_t state, state_nx;
    logic [SW-1:0] settle_cnt;
    logic accept, release_now, settle_end;

    assign accept      = (state == ST_ON_QUAL)  && det_s  && guard_done;
    assign release_now = (state == ST_OFF_QUAL) && !det_s && guard_done;
    assign settle_end  = (state == ST_SETTLE)   && (settle_cnt == SETTLE_LAST);
    assign timer_run   = (state == ST_ON_QUAL) || (state == ST_OFF_QUAL);
    assign sel_on      = (state == ST_ON_QUAL);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (det_s) state_nx = ST_ON_QUAL;
            ST_ON_QUAL:  if (!det_s) state_nx = ST_IDLE;
                         else if (guard_done) state_nx = ST_SETTLE;
            ST_SETTLE:   if (settle_end) state_nx = ST_HELD;
            ST_HELD:     if (!det_s) state_nx = ST_OFF_QUAL;
            ST_OFF_QUAL: if (det_s) state_nx = ST_HELD;
                         else if (guard_done) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register and settle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            settle_cnt <= '0;
        end else begin
            state      <= state_nx;
            settle_cnt <= (state == ST_SETTLE && !settle_end) ? settle_cnt + 1'b1 : '0;
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_code     <= '0;
            steer_idle  <= 1'b1;
            code_strobe <= 1'b0;
        end else begin
            code_strobe <= accept;
            if (accept)      rx_code    <= code_s;
            if (settle_end)  steer_idle <= 1'b0;
            if (release_now) steer_idle <= 1'b1;
        end
    end

    AST_CODE_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_code) |-> code_strobe); // R3
    AST_STROBE_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        code_strobe |=> !code_strobe); // R2
    AST_IDLE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        code_strobe |-> steer_idle); // R7
    AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(steer_idle) |-> $past(code_strobe, 2)); // R7
    AST_HOLD_WHILE_DET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HELD && det_s) |=> (state == ST_HELD && !code_strobe)); // R4
    AST_DROPOUT_NO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF_QUAL && !guard_done) |=> !steer_idle); // R5
endmodule

// File: rtl/dtmf_steer_top.sv
module dtmf_steer_top
    import steer_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               pair_det,
    input  logic [CODE_W-1:0]  det_code,
    input  logic [GUARD_W-1:0] on_guard,
    input  logic [GUARD_W-1:0] off_guard,
    output logic [CODE_W-1:0]  rx_code,
    output logic               steer_idle,
    output logic               code_strobe
);
    localparam int SYNC_W = CODE_W + 1;

    logic [SYNC_W-1:0] sync_q;
    logic              det_s;
    logic [CODE_W-1:0] code_s;
    logic              timer_run, sel_on, guard_done;
    logic [GUARD_W-1:0] limit;

    steer_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({pair_det, det_code}),
        .q     (sync_q)
    );

    assign det_s  = sync_q[SYNC_W-1];
    assign code_s = sync_q[CODE_W-1:0];
    assign limit  = sel_on ? on_guard : off_guard;

    steer_guard_timer #(.W(GUARD_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (timer_run),
        .tick  (tick),
        .limit (limit),
        .done  (guard_done)
    );

    steer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .det_s       (det_s),
        .code_s      (code_s),
        .guard_done  (guard_done),
        .timer_run   (timer_run),
        .sel_on      (sel_on),
        .rx_code     (rx_code),
        .steer_idle  (steer_idle),
        .code_strobe (code_strobe)
    );
endmodule

// File: tb/sim_dtmf_steer_top.sv
`timescale 1ns/1ps
module sim_dtmf_steer_top;
    localparam int TICKP = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pair_det = 1'b0;
    logic [3:0]  det_code = 4'd0;
    logic [15:0] on_guard = 16'd5;
    logic [15:0] off_guard = 16'd4;
    logic [3:0]  rx_code;
    logic        steer_idle;
    logic        code_strobe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [3:0] exp_q[$];

    always #4 clk = ~clk;

    dtmf_steer_top u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pair_det(pair_det),
        .det_code(det_code), .on_guard(on_guard), .off_guard(off_guard),
        .rx_code(rx_code), .steer_idle(steer_idle), .code_strobe(code_strobe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        forever begin
            for (int i = 0; i < TICKP - 1; i++) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    task automatic hold(input logic level, input int ticks);
        pair_det = level;
        repeat (ticks * TICKP) @(negedge clk);
    endtask

    // Driver: one tone of ticks_on ticks followed by ticks_off ticks of silence
    task automatic tone(input logic [3:0] code, input int ticks_on, input int ticks_off,
                        input bit accept);
        det_code = code;
        if (accept) exp_q.push_back(code);
        hold(1'b1, ticks_on);
        hold(1'b0, ticks_off);
    endtask

    // Monitor: scoreboard compare on every strobe
    initial begin
        logic [3:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && code_strobe) begin
                if (exp_q.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R3 actual=strobe(%0h) expected=no strobe at %0t", rx_code, $time);
                end else begin
                    e = exp_q.pop_front();
                    check("R2/R9 stored code", {4'd0, rx_code}, {4'd0, e});
                    check("R7 idle during strobe", {7'd0, steer_idle}, 8'd1);
                    @(negedge clk);
                    check("R2 strobe one wide", {7'd0, code_strobe}, 8'd0);
                    check("R7 idle one clock after", {7'd0, steer_idle}, 8'd1);
                    @(negedge clk);
                    check("R7 idle falls two clocks after", {7'd0, steer_idle}, 8'd0);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rx_code", {4'd0, rx_code}, 8'd0);
        check("R1 steer_idle", {7'd0, steer_idle}, 8'd1);
        check("R1 code_strobe", {7'd0, code_strobe}, 8'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R2/R6: accepted tone then valid end
        tone(4'h7, 12, 10, 1'b1);
        check("R6 idle after end", {7'd0, steer_idle}, 8'd1);
        check("R6 code kept", {4'd0, rx_code}, 8'h07);

        // R3: short burst rejected
        tone(4'h3, 2, 8, 1'b0);
        check("R3 code unchanged", {4'd0, rx_code}, 8'h07);
        check("R3 still idle", {7'd0, steer_idle}, 8'd1);

        // R4/R5: long tone with a short dropout
        det_code = 4'hA;
        exp_q.push_back(4'hA);
        hold(1'b1, 12);
        check("R4 held while present", {7'd0, steer_idle}, 8'd0);
        hold(1'b0, 1);
        check("R5 held during dropout", {7'd0, steer_idle}, 8'd0);
        hold(1'b1, 3);
        check("R5 code kept after dropout", {4'd0, rx_code}, 8'h0A);
        check("R5 still held", {7'd0, steer_idle}, 8'd0);
        hold(1'b0, 10);
        check("R6 released", {7'd0, steer_idle}, 8'd1);

        // R8: short on-guard, long off-guard
        on_guard = 16'd2; off_guard = 16'd9;
        repeat (4) @(negedge clk);
        det_code = 4'h5;
        exp_q.push_back(4'h5);
        hold(1'b1, 5);
        hold(1'b0, 4);
        check("R8 long off-guard rides gap", {7'd0, steer_idle}, 8'd0);
        hold(1'b1, 2);
        hold(1'b0, 14);
        check("R8 release after long off-guard", {7'd0, steer_idle}, 8'd1);

        // R8: long on-guard, short off-guard
        on_guard = 16'd9; off_guard = 16'd2;
        repeat (4) @(negedge clk);
        tone(4'hC, 5, 6, 1'b0);
        check("R8 long on-guard rejects", {4'd0, rx_code}, 8'h05);
        tone(4'h0, 14, 6, 1'b1);
        check("R9 next code", {4'd0, rx_code}, 8'h00);
        check("R8 short off-guard release", {7'd0, steer_idle}, 8'd1);

        check("R9 all expected strobes seen", exp_q.size(), 8'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule